// File: doc/BRIEF.md
# Multi-CPU Interrupt Enable and Routing Distributor

This block collects level-sensitive interrupt lines and steers them to a small set of CPUs. The low-numbered sources are private: each CPU owns its own copy of these lines. The rest are shared: one line per source, passed to whichever CPUs its routing register names. Each CPU reads one register to learn which source to service next, and it has one interrupt output that stays high while anything is waiting for it.

Software never edits bit vectors. To change one gate bit, it writes the source number to a register: one register sets the bit and its partner clears it. There is a pair for the global enable of shared sources and a pair for each CPU's private mask. The writing CPU is named on the register port, so a mask write only touches that CPU's mask. When several sources are eligible, the lowest number wins. When none is eligible, a fixed spurious code is returned.

Top module: `irq_route_hub`

## Requirements
- R1: After reset every shared enable is clear and every per-CPU mask bit is set. Every routing register holds the value 1 (CPU 0 only). Every acknowledge read returns the spurious code and every `cpu_irq` bit is low.
- R2: A write of number n to global offset 0x030 enables shared source n. A write of n to global offset 0x034 disables it. A disabled shared source never reaches any CPU.
- R3: A write of n to per-CPU offset 0x048 masks source n for the CPU selected by `reg_cpu` only. A write of n to per-CPU offset 0x04C unmasks it. A masked source is never acknowledged to that CPU.
- R4: Sources 0 to PRIV_N-1 (0 to 28 by default) are private. The private line for CPU c and source n is `prv_in[c*PRIV_N+n]`. Such a source is gated only by that CPU's mask. Enable writes naming a private source have no effect, and its routing register reads 0 and ignores writes.
- R5: The routing register of source n sits at global offset 0x100+4*n. Its bits [NUM_CPU-1:0] are the set of CPUs that receive the source, bit c meaning CPU c. It reads back what was written.
- R6: A read of global offset 0x000 returns NUM_SRC in bits [11:2] and zero in every other bit.
- R7: A read of per-CPU offset 0x044 returns, in bits [9:0], the lowest-numbered source eligible for the selected CPU. A shared source is eligible when it is asserted, enabled, routed to that CPU and unmasked for it. A private source is eligible when its line for that CPU is asserted and it is unmasked for that CPU.
- R8: When no source is eligible for the selected CPU, the acknowledge read returns 0x3FF.
- R9: `cpu_irq[c]` is high exactly while at least one source is eligible for CPU c.
- R10: A set, clear, mask or unmask write naming a number at or above NUM_SRC changes no state, even when its low bits equal a valid source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_bank | input | 1 | 0 selects the global bank, 1 selects the per-CPU bank |
| reg_cpu | input | CPU_W | CPU that issues the access (per-CPU bank) |
| reg_addr | input | ADDR_W | Byte offset within the selected bank |
| reg_wdata | input | 32 | Write data (source number or routing set) |
| reg_rdata | output | 32 | Read data for the current address, combinational |
| shr_in | input | NUM_SRC-PRIV_N | Shared source lines; bit k is source PRIV_N+k |
| prv_in | input | NUM_CPU*PRIV_N | Private source lines, one group of PRIV_N per CPU |
| cpu_irq | output | NUM_CPU | Interrupt request to each CPU |

## Verification
A single shared source is walked through each of its gates: asserted, enabled, unmasked and routed. The bench then removes one gate at a time, which separates the global enable, the per-CPU mask and the routing bits. Private lines driven for one CPU only, mixed with enable writes that name private numbers, show that private sources ignore the global enable and do not leak to other CPUs. Overlapping private and shared requests on one CPU check the lowest-number rule as lines drop away one by one. Writes with out-of-range numbers that alias a live source in their low bits show whether the number is compared in full width.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
  localparam logic [9:0]  SPUR_CODE     = 10'h3FF;
  localparam logic [11:0] OFF_CTRL      = 12'h000;
  localparam logic [11:0] OFF_EN_SET    = 12'h030;
  localparam logic [11:0] OFF_EN_CLR    = 12'h034;
  localparam logic [11:0] OFF_ACK       = 12'h044;
  localparam logic [11:0] OFF_MSK_SET   = 12'h048;
  localparam logic [11:0] OFF_MSK_CLR   = 12'h04C;
  localparam logic [11:0] OFF_ROUTE_BASE = 12'h100;

  // Control word: source count in bits [11:2]
  function automatic logic [31:0] ctrl_word(input int nsrc);
    logic [9:0] n10;
    n10 = 10'(nsrc);
    return {20'd0, n10, 2'b00};
  endfunction
endpackage

// File: rtl/irq_en_bank.sv
`timescale 1ns/1ps
module irq_en_bank #(
  parameter int NUM_SRC = 40,
  parameter int NUM_CPU = 4,
  parameter int PRIV_N  = 29,
  localparam int NUM_SHR = NUM_SRC - PRIV_N,
  localparam int SLOT_W  = (NUM_SHR > 1) ? $clog2(NUM_SHR) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       set_wr,
  input  logic                       clr_wr,
  input  logic [31:0]                idx,
  input  logic                       rt_wr,
  input  logic [SLOT_W-1:0]          rt_slot,
  input  logic [NUM_CPU-1:0]         rt_data,
  input  logic [NUM_SHR-1:0]         shr_in,
  output logic [NUM_SHR-1:0]         shr_live,
  output logic [NUM_SHR*NUM_CPU-1:0] route_flat
);
  logic [NUM_SHR-1:0] en_q;
  logic [NUM_CPU-1:0] route_q [NUM_SHR];

  // Named events for the assertions
  wire idx_shared = (idx >= 32'(PRIV_N)) && (idx < 32'(NUM_SRC));
  wire set_ok     = set_wr && idx_shared;
  wire clr_ok     = clr_wr && idx_shared;
  wire oor_wr     = (set_wr || clr_wr) && (idx >= 32'(NUM_SRC));
  wire [SLOT_W-1:0] slot = SLOT_W'(idx - 32'(PRIV_N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (set_ok) begin
      en_q[slot] <= 1'b1;
    end else if (clr_ok) begin
      en_q[slot] <= 1'b0;
    end
  end

  for (genvar k = 0; k < NUM_SHR; k++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) route_q[k] <= NUM_CPU'(1);
      else if (rt_wr && rt_slot == SLOT_W'(k)) route_q[k] <= rt_data;
    end
    assign route_flat[k*NUM_CPU +: NUM_CPU] = route_q[k];
  end

  assign shr_live = shr_in & en_q;

  AST_CLR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok |=> !shr_live[$past(slot)]); // R2
  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    oor_wr |=> $stable(en_q)); // R10
endmodule

// File: rtl/irq_cpu_slice.sv
`timescale 1ns/1ps
module irq_cpu_slice
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int PRIV_N  = 29,
  localparam int NUM_SHR = NUM_SRC - PRIV_N,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msk_set,
  input  logic               msk_clr,
  input  logic [31:0]        idx,
  input  logic [PRIV_N-1:0]  prv_in,
  input  logic [NUM_SHR-1:0] shr_live,
  input  logic [NUM_SHR-1:0] route_bit,
  output logic [9:0]         ack,
  output logic               irq
);
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] elig;

  wire idx_ok = idx < 32'(NUM_SRC);
  wire [IDX_W-1:0] bit_sel = idx[IDX_W-1:0];

  function automatic logic [9:0] pick_lowest(input logic [NUM_SRC-1:0] v);
    logic [9:0] r;
    r = SPUR_CODE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = 10'(i);
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (msk_set && idx_ok) begin
      mask_q[bit_sel] <= 1'b1;
    end else if (msk_clr && idx_ok) begin
      mask_q[bit_sel] <= 1'b0;
    end
  end

  assign elig = {shr_live & route_bit, prv_in} & ~mask_q;
  assign ack  = pick_lowest(elig);
  assign irq  = |elig;

  AST_IRQ_ACK_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (ack != SPUR_CODE)); // R9
  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_set && idx_ok) |=> (ack != $past(idx[9:0]))); // R3
  AST_ACK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack < 10'(NUM_SRC)) || (ack == SPUR_CODE)); // R7
  AST_PRIV_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack < 10'(PRIV_N)) |-> prv_in[ack]); // R4
endmodule

// File: rtl/irq_route_hub.sv
`timescale 1ns/1ps
module irq_route_hub
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CPU = 4,
  parameter int PRIV_N  = 29,
  parameter int ADDR_W  = 12,
  localparam int NUM_SHR = NUM_SRC - PRIV_N,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int SLOT_W  = (NUM_SHR > 1) ? $clog2(NUM_SHR) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic                      reg_bank,
  input  logic [CPU_W-1:0]          reg_cpu,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic [NUM_SHR-1:0]        shr_in,
  input  logic [NUM_CPU*PRIV_N-1:0] prv_in,
  output logic [NUM_CPU-1:0]        cpu_irq
);
  logic [NUM_SHR-1:0]         shr_live;
  logic [NUM_SHR*NUM_CPU-1:0] route_flat;
  logic [9:0]                 ack_all [NUM_CPU];

  // Register decode
  wire g_wr = reg_wr && !reg_bank;
  wire c_wr = reg_wr && reg_bank;
  wire en_set = g_wr && (reg_addr == ADDR_W'(OFF_EN_SET));
  wire en_clr = g_wr && (reg_addr == ADDR_W'(OFF_EN_CLR));

  wire [ADDR_W-1:0] rt_off = reg_addr - ADDR_W'(OFF_ROUTE_BASE);
  wire [ADDR_W-1:0] rt_src = rt_off >> 2;
  wire rt_hit = (reg_addr >= ADDR_W'(OFF_ROUTE_BASE)) && (reg_addr[1:0] == 2'b00)
                && (rt_src < ADDR_W'(NUM_SRC));
  wire rt_shared = rt_hit && (rt_src >= ADDR_W'(PRIV_N));
  wire [SLOT_W-1:0] rt_slot = SLOT_W'(rt_src - ADDR_W'(PRIV_N));
  wire rt_wr = g_wr && rt_shared;

  irq_en_bank #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .PRIV_N(PRIV_N)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .set_wr(en_set), .clr_wr(en_clr), .idx(reg_wdata),
    .rt_wr(rt_wr), .rt_slot(rt_slot), .rt_data(reg_wdata[NUM_CPU-1:0]),
    .shr_in(shr_in), .shr_live(shr_live), .route_flat(route_flat)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SHR-1:0] route_col;
    for (genvar k = 0; k < NUM_SHR; k++) begin : g_col
      assign route_col[k] = route_flat[k*NUM_CPU + c];
    end
    wire sel = (reg_cpu == CPU_W'(c));
    irq_cpu_slice #(.NUM_SRC(NUM_SRC), .PRIV_N(PRIV_N)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .msk_set(c_wr && sel && (reg_addr == ADDR_W'(OFF_MSK_SET))),
      .msk_clr(c_wr && sel && (reg_addr == ADDR_W'(OFF_MSK_CLR))),
      .idx(reg_wdata),
      .prv_in(prv_in[c*PRIV_N +: PRIV_N]),
      .shr_live(shr_live), .route_bit(route_col),
      .ack(ack_all[c]), .irq(cpu_irq[c])
    );
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (!reg_bank) begin
      if (reg_addr == ADDR_W'(OFF_CTRL)) reg_rdata = ctrl_word(NUM_SRC);
      else if (rt_shared) reg_rdata[NUM_CPU-1:0] = route_flat[rt_slot*NUM_CPU +: NUM_CPU];
    end else if (reg_addr == ADDR_W'(OFF_ACK)) begin
      reg_rdata[9:0] = ack_all[reg_cpu];
    end
  end

  AST_PRIV_ROUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_bank && rt_hit && !rt_shared) |-> (reg_rdata == 32'd0)); // R4
endmodule

// File: tb/irq_route_hub_test.sv
`timescale 1ns/1ps
module irq_route_hub_test;
  localparam int NS = 40, NC = 4, PN = 29, NH = NS - PN;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_bank = 1'b0;
  logic [1:0] reg_cpu = '0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NH-1:0] shr_in = '0;
  logic [NC*PN-1:0] prv_in = '0;
  logic [NC-1:0] cpu_irq;

  always #2.5 clk = ~clk;

  irq_route_hub uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_bank(reg_bank),
    .reg_cpu(reg_cpu), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .shr_in(shr_in), .prv_in(prv_in), .cpu_irq(cpu_irq));

  // Requirement model
  logic m_en [NS];
  logic m_mask [NC][NS];
  logic [3:0] m_route [NS];
  int checks = 0, fails = 0;

  logic [31:0] q_data [$];
  logic [3:0]  q_irq [$];
  string       q_tag [$];

  function automatic logic [9:0] model_ack(input int c);
    for (int n = 0; n < NS; n++) begin
      if (n < PN) begin
        if (prv_in[c*PN+n] && !m_mask[c][n]) return 10'(n);
      end else if (shr_in[n-PN] && m_en[n] && m_route[n][c] && !m_mask[c][n]) begin
        return 10'(n);
      end
    end
    return 10'h3FF;
  endfunction

  function automatic logic [3:0] model_irq();
    logic [3:0] v;
    for (int c = 0; c < NC; c++) v[c] = (model_ack(c) != 10'h3FF);
    return v;
  endfunction

  task automatic wr(input logic bank, input int cpu, input int addr, input int data);
    reg_bank = bank; reg_cpu = 2'(cpu); reg_addr = 12'(addr); reg_wdata = 32'(data);
    reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic en_set(input int n);
    wr(1'b0, 0, 'h30, n);
    if (n >= PN && n < NS) m_en[n] = 1'b1;
  endtask
  task automatic en_clr(input int n);
    wr(1'b0, 0, 'h34, n);
    if (n >= PN && n < NS) m_en[n] = 1'b0;
  endtask
  task automatic msk(input int c, input int n);
    wr(1'b1, c, 'h48, n);
    if (n < NS) m_mask[c][n] = 1'b1;
  endtask
  task automatic unmsk(input int c, input int n);
    wr(1'b1, c, 'h4C, n);
    if (n < NS) m_mask[c][n] = 1'b0;
  endtask
  task automatic route(input int n, input int v);
    wr(1'b0, 0, 'h100 + 4*n, v);
    if (n >= PN && n < NS) m_route[n] = 4'(v);
  endtask

  // Driver: present a read and push the expectation
  task automatic probe(input logic bank, input int cpu, input int addr,
                       input logic [31:0] exp, input string tag);
    reg_bank = bank; reg_cpu = 2'(cpu); reg_addr = 12'(addr);
    q_data.push_back(exp); q_irq.push_back(model_irq()); q_tag.push_back(tag);
    @(posedge clk); #1;
  endtask
  task automatic probe_ack(input int c, input string tag);
    probe(1'b1, c, 'h44, {22'd0, model_ack(c)}, tag);
  endtask

  // Monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (q_data.size() > 0) begin
      logic [31:0] ed; logic [3:0] ei; string t;
      ed = q_data.pop_front(); ei = q_irq.pop_front(); t = q_tag.pop_front();
      checks++;
      if (reg_rdata !== ed) begin
        fails++;
        $display("FAIL %s rdata actual=%h expected=%h", t, reg_rdata, ed);
      end
      checks++;
      if (cpu_irq !== ei) begin
        fails++;
        $display("FAIL %s (R9) cpu_irq actual=%b expected=%b", t, cpu_irq, ei);
      end
    end
  end

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int n = 0; n < NS; n++) begin
      m_en[n] = 1'b0; m_route[n] = (n >= PN) ? 4'd1 : 4'd0;
      for (int c = 0; c < NC; c++) m_mask[c][n] = 1'b1;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 / R8 reset state
    for (int c = 0; c < NC; c++) probe(1'b1, c, 'h44, 32'h3FF, "R1 R8 reset ack");
    probe(1'b0, 0, 'h100 + 4*30, 32'd1, "R1 reset route");
    // R6 control word
    probe(1'b0, 0, 'h000, 32'(NS) << 2, "R6 source count");

    // R2 shared source 35 through its gates
    shr_in[35-PN] = 1'b1;
    probe_ack(0, "R2 asserted but disabled");
    en_set(35);
    probe_ack(0, "R1 enabled but masked");
    unmsk(0, 35);
    probe(1'b1, 0, 'h44, 32'd35, "R2 R7 enabled unmasked");
    unmsk(1, 35);
    probe(1'b1, 1, 'h44, 32'h3FF, "R5 not routed to cpu1");
    route(35, 2);
    probe(1'b0, 0, 'h100 + 4*35, 32'd2, "R5 route readback");
    probe(1'b1, 1, 'h44, 32'd35, "R5 routed to cpu1");
    probe(1'b1, 0, 'h44, 32'h3FF, "R5 removed from cpu0");
    // R10 aliasing out-of-range clear (35+64)
    en_clr(35 + 64);
    probe(1'b1, 1, 'h44, 32'd35, "R10 oor clear ignored");
    msk(1, 35 + 64);
    probe_ack(1, "R10 oor mask ignored");
    en_clr(35);
    probe(1'b1, 1, 'h44, 32'h3FF, "R2 cleared enable");

    // R4 private sources
    prv_in[2*PN + 5] = 1'b1;
    unmsk(2, 5);
    probe(1'b1, 2, 'h44, 32'd5, "R4 private delivered");
    unmsk(3, 5);
    probe(1'b1, 3, 'h44, 32'h3FF, "R4 private line is per cpu");
    en_clr(5);
    probe(1'b1, 2, 'h44, 32'd5, "R4 enable write ignored");
    route(5, 15);
    probe(1'b0, 0, 'h100 + 4*5, 32'd0, "R4 private route reads zero");

    // R7 lowest number wins
    prv_in[2*PN + 3] = 1'b1;
    unmsk(2, 3);
    probe(1'b1, 2, 'h44, 32'd3, "R7 lower private wins");
    shr_in[30-PN] = 1'b1;
    en_set(30); route(30, 4); unmsk(2, 30);
    probe_ack(2, "R7 shared behind private");
    prv_in[2*PN + 3] = 1'b0; prv_in[2*PN + 5] = 1'b0;
    probe(1'b1, 2, 'h44, 32'd30, "R7 shared after privates drop");
    en_set(35); route(35, 4); unmsk(2, 35);
    probe(1'b1, 2, 'h44, 32'd30, "R7 30 before 35");
    // R3 mask only the writing cpu
    msk(2, 30);
    probe(1'b1, 2, 'h44, 32'd35, "R3 masked 30 on cpu2");
    route(30, 5); unmsk(0, 30);
    probe(1'b1, 0, 'h44, 32'd30, "R3 cpu0 unaffected by cpu2 mask");
    msk(2, 35);
    probe(1'b1, 2, 'h44, 32'h3FF, "R3 R8 all masked");
    unmsk(2, 35 + 64);
    probe(1'b1, 2, 'h44, 32'h3FF, "R10 oor unmask ignored");

    @(posedge clk); @(negedge clk); #1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule